// File: doc/BRIEF.md
# Masked Barrier and Eureka Synchronisation Tree

This block joins one synchronisation bit from each of `N_NODES` leaf nodes through a binary tree of combine stages. Each stage holds one register. The result goes back down the same tree to every participating node. In barrier mode a round finishes when every participating node has raised its bit. In eureka mode a round finishes as soon as any participating node raises its bit. A per-node participation mask removes single nodes from the round. A per-subtree cut bit makes an inner tree node act as the root of its own smaller round.

Each node sets its bit to arrive. When the round completes, the node sees its completion flag set. If the node has enabled interrupts, it also sees a one-cycle interrupt pulse. Before the node can take part in another round, it must drop its bit for at least one cycle. A bit that stays high after a completion is not counted again. Tree nodes use heap numbering: the root is node 1, the children of node k are 2k and 2k+1, and leaf i sits at position `N_NODES + i`. The height h of a tree node is the number of register levels below it, so the root has height log2(`N_NODES`).

Top module: `sync_tree`

## Requirements
- R1: In barrier mode (`mode_eureka` = 0), if every participating node in the root's reach has a counted arrival, the root completes. Counting edges from the first clock edge that samples the last arrival, `done_irq` is high after edge 2·log2(`N_NODES`) and not before.
- R2: In barrier mode, while any participating node in reach lacks a counted arrival, no completion occurs. `done_irq` and `done_flag` stay 0.
- R3: In eureka mode (`mode_eureka` = 1), one counted arrival from any participating node completes the round for every participating node in reach, with the same latency as R1.
- R4: A node whose `node_mask` bit is 0 counts as arrived in barrier mode and as silent in eureka mode. It never receives `done_flag` or `done_irq`.
- R5: If `subtree_bypass[k]` is 1, tree node k resolves its own subtree 2·h cycles after its last needed arrival, where h is the height of node k. It presents the neutral value to its parent (1 in barrier mode, 0 in eureka mode), and a completion from above does not enter its subtree.
- R6: On completion, `done_irq[i]` is high for exactly one cycle, and only if `irq_en[i]` is 1. `done_flag[i]` goes to 1 one cycle after the delivery, whether or not `irq_en[i]` is set.
- R7: `done_flag[i]` stays 1 until node i makes its next counted arrival. It clears on the edge that samples that arrival.
- R8: After a completion, a node's bit counts only after the node has held it low for at least one cycle. A bit that stays high is treated as not arrived.
- R9: A resolving tree node delivers exactly one completion per round, even if its inputs stay satisfied.
- R10: While `rst_n` is low and after its release, `done_irq` and `done_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_eureka | input | 1 | 0 = barrier (all), 1 = eureka (any) |
| node_bit | input | N_NODES | Arrival bit of each leaf node |
| node_mask | input | N_NODES | 1 = node participates |
| subtree_bypass | input | N_NODES-2 (bits N_NODES-1..2) | Bit k makes tree node k resolve locally |
| irq_en | input | N_NODES | 1 = deliver completion as an interrupt pulse |
| done_irq | output | N_NODES | One-cycle completion interrupt per node |
| done_flag | output | N_NODES | Polled completion status per node |

## Verification
The bench builds the tree with `N_NODES` = 8, which gives three register levels and a root round-trip of exactly six cycles. That size is large enough to cut the tree at a middle node (node 2, four-cycle local round) and at a bottom node (node 7, two-cycle local round). It can then show that the rest of the tree neither waits on nor delivers into a cut subtree. It also places the re-arm rules, the mask neutrals of both modes and the interrupt/poll split on exact cycles.

// File: rtl/sync_tree_pkg.sv
package sync_tree_pkg;

  typedef enum logic {
    SYNC_BARRIER = 1'b0,
    SYNC_EUREKA  = 1'b1
  } sync_mode_e;

  // Value a silent or cut-off input offers to its parent.
  function automatic logic idle_value(input sync_mode_e m);
    return (m == SYNC_BARRIER);
  endfunction

  // Two-input combine: all-of in barrier mode, any-of in eureka mode.
  function automatic logic merge2(input sync_mode_e m, input logic a, input logic b);
    return (m == SYNC_EUREKA) ? (a | b) : (a & b);
  endfunction

endpackage

// File: rtl/sync_tree_leaf.sv
module sync_tree_leaf
  import sync_tree_pkg::*;
#(
  parameter int unsigned N_NODES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sync_mode_e         mode,
  input  logic [N_NODES-1:0] node_bit,
  input  logic [N_NODES-1:0] node_mask,
  input  logic [N_NODES-1:0] irq_en,
  input  logic [N_NODES-1:0] deliver_raw,
  output logic [N_NODES-1:0] leaf_val,
  output logic [N_NODES-1:0] deliver,
  output logic [N_NODES-1:0] done_irq,
  output logic [N_NODES-1:0] done_flag
);

  for (genvar i = 0; i < N_NODES; i++) begin : g_leaf
    logic armed_q;
    logic flag_q;
    logic take;
    logic counted;

    assign take    = deliver_raw[i] & node_mask[i];
    assign counted = node_bit[i] & armed_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed_q <= 1'b1;
        flag_q  <= 1'b0;
      end else begin
        // completion disarms; a low bit re-arms
        if (take)              armed_q <= 1'b0;
        else if (!node_bit[i]) armed_q <= 1'b1;
        // flag held until next counted arrival
        if (take)              flag_q  <= 1'b1;
        else if (counted)      flag_q  <= 1'b0;
      end
    end

    assign leaf_val[i]  = node_mask[i] ? counted : idle_value(mode);
    assign deliver[i]   = take;
    assign done_irq[i]  = take & irq_en[i];
    assign done_flag[i] = flag_q;
  end

endmodule

// File: rtl/sync_tree_up.sv
module sync_tree_up
  import sync_tree_pkg::*;
#(
  parameter int unsigned N_NODES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sync_mode_e         mode,
  input  logic [N_NODES-1:0] leaf_val,
  input  logic [N_NODES-1:2] bypass,
  output logic [N_NODES-1:1] up_q
);

  localparam int unsigned SLOTS = 2 * N_NODES;

  // value each heap position hands to its parent
  logic [SLOTS-1:2] offer;

  for (genvar i = 0; i < N_NODES; i++) begin : g_leaf_offer
    assign offer[N_NODES + i] = leaf_val[i];
  end

  for (genvar k = 2; k < N_NODES; k++) begin : g_inner_offer
    assign offer[k] = bypass[k] ? idle_value(mode) : up_q[k];
  end

  for (genvar k = 1; k < N_NODES; k++) begin : g_stage
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= merge2(mode, offer[2*k], offer[2*k+1]);
    end
    assign up_q[k] = q;
  end

endmodule

// File: rtl/sync_tree_down.sv
module sync_tree_down #(
  parameter int unsigned N_NODES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:1] up_q,
  input  logic [N_NODES-1:2] bypass,
  output logic [N_NODES-1:1] fire,
  output logic [N_NODES-1:0] deliver_raw
);

  logic [N_NODES-1:1] dn_q;

  for (genvar k = 1; k < N_NODES; k++) begin : g_node
    logic lock_q;
    logic dn;
    logic resolver;
    logic from_above;

    if (k == 1) begin : g_root
      assign resolver   = 1'b1;
      assign from_above = 1'b0;
    end else begin : g_inner
      assign resolver   = bypass[k];
      assign from_above = ~bypass[k] & dn_q[k/2];
    end

    // one completion per round: lock until the combined value drops
    assign fire[k] = up_q[k] & resolver & ~lock_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lock_q <= 1'b0;
        dn     <= 1'b0;
      end else begin
        if (fire[k])       lock_q <= 1'b1;
        else if (!up_q[k]) lock_q <= 1'b0;
        dn <= fire[k] | from_above;
      end
    end
    assign dn_q[k] = dn;
  end

  for (genvar i = 0; i < N_NODES; i++) begin : g_out
    assign deliver_raw[i] = dn_q[(N_NODES + i) / 2];
  end

endmodule

// File: rtl/sync_tree.sv
module sync_tree
  import sync_tree_pkg::*;
#(
  parameter int unsigned N_NODES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_eureka,
  input  logic [N_NODES-1:0] node_bit,
  input  logic [N_NODES-1:0] node_mask,
  input  logic [N_NODES-1:2] subtree_bypass,
  input  logic [N_NODES-1:0] irq_en,
  output logic [N_NODES-1:0] done_irq,
  output logic [N_NODES-1:0] done_flag
);

  sync_mode_e         mode_w;
  logic [N_NODES-1:0] leaf_val_w;
  logic [N_NODES-1:0] deliver_w;
  logic [N_NODES-1:0] deliver_raw_w;
  logic [N_NODES-1:1] up_w;
  logic [N_NODES-1:1] fire_w;

  assign mode_w = sync_mode_e'(mode_eureka);

  sync_tree_leaf #(.N_NODES(N_NODES)) leaf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_w),
    .node_bit    (node_bit),
    .node_mask   (node_mask),
    .irq_en      (irq_en),
    .deliver_raw (deliver_raw_w),
    .leaf_val    (leaf_val_w),
    .deliver     (deliver_w),
    .done_irq    (done_irq),
    .done_flag   (done_flag)
  );

  sync_tree_up #(.N_NODES(N_NODES)) up_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_w),
    .leaf_val (leaf_val_w),
    .bypass   (subtree_bypass),
    .up_q     (up_w)
  );

  sync_tree_down #(.N_NODES(N_NODES)) down_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_q        (up_w),
    .bypass      (subtree_bypass),
    .fire        (fire_w),
    .deliver_raw (deliver_raw_w)
  );

endmodule

// File: rtl/sync_tree_chk.sv
module sync_tree_chk #(
  parameter int unsigned N_NODES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_NODES-1:0] node_mask,
  input logic [N_NODES-1:0] done_irq,
  input logic [N_NODES-1:0] done_flag,
  input logic [N_NODES-1:0] deliver,
  input logic [N_NODES-1:0] leaf_val,
  input logic [N_NODES-1:1] fire
);

  for (genvar i = 0; i < N_NODES; i++) begin : g_leaf_chk
    assert_irq_then_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq[i] |=> done_flag[i]);

    assert_masked_never_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!node_mask[i] && !done_flag[i]) |=> !done_flag[i]);

    assert_flag_from_delivery_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag[i]) |-> $past(deliver[i]));

    assert_held_bit_not_counted_R8: assert property (@(posedge clk) disable iff (!rst_n)
      deliver[i] |=> (!node_mask[i] || !leaf_val[i]));
  end

  for (genvar k = 1; k < N_NODES; k++) begin : g_node_chk
    assert_single_completion_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fire[k] |=> !fire[k]);
  end

endmodule

bind sync_tree sync_tree_chk #(.N_NODES(N_NODES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .node_mask (node_mask),
  .done_irq  (done_irq),
  .done_flag (done_flag),
  .deliver   (deliver_w),
  .leaf_val  (leaf_val_w),
  .fire      (fire_w)
);

// File: tb/sync_tree_tb_top.sv
module sync_tree_tb_top;

  localparam int unsigned N          = 8;
  localparam time         CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_eureka = 1'b0;
  logic [N-1:0] node_bit = '0;
  logic [N-1:0] node_mask = '1;
  logic [N-1:2] subtree_bypass = '0;
  logic [N-1:0] irq_en = '1;
  logic [N-1:0] done_irq;
  logic [N-1:0] done_flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tree #(.N_NODES(N)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_eureka    (mode_eureka),
    .node_bit       (node_bit),
    .node_mask      (node_mask),
    .subtree_bypass (subtree_bypass),
    .irq_en         (irq_en),
    .done_irq       (done_irq),
    .done_flag      (done_flag)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait n rising edges, then settle at the following falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic [N-1:0] msk,
                          input logic [N-1:2] byp, input logic [N-1:0] ien);
    @(negedge clk);
    rst_n          = 1'b0;
    node_bit       = '0;
    mode_eureka    = m;
    node_mask      = msk;
    subtree_bypass = byp;
    irq_en         = ien;
    edges(2);
    chk("R10 irq in reset", done_irq, '0);
    chk("R10 flag in reset", done_flag, '0);
    rst_n = 1'b1;
    edges(1);
    chk("R10 flag after reset", done_flag, '0);
  endtask

  task automatic t_barrier_round;
    do_reset(1'b0, 8'hFF, '0, 8'hFF);
    node_bit = 8'h7F;
    edges(8);
    chk("R2 irq with one missing", done_irq, 8'h00);
    chk("R2 flag with one missing", done_flag, 8'h00);
    node_bit = 8'hFF;
    edges(5);
    chk("R1 irq before latency", done_irq, 8'h00);
    edges(1);
    chk("R1 irq at 2*levels", done_irq, 8'hFF);
    edges(1);
    chk("R6 irq one cycle", done_irq, 8'h00);
    chk("R7 flag set", done_flag, 8'hFF);
    edges(10);
    chk("R9 no second completion", done_irq, 8'h00);
    chk("R7 flag held", done_flag, 8'hFF);
    // nodes 1..7 re-arm, node 0 keeps its bit high
    node_bit = 8'h01;
    edges(1);
    node_bit = 8'hFF;
    edges(10);
    chk("R8 held bit not counted", done_irq, 8'h00);
    chk("R7 flag clears on counted arrival", done_flag, 8'h01);
    node_bit = 8'hFE;
    edges(1);
    node_bit = 8'hFF;
    edges(5);
    chk("R8 not yet complete", done_irq, 8'h00);
    edges(1);
    chk("R8 re-armed round completes", done_irq, 8'hFF);
  endtask

  task automatic t_barrier_mask;
    do_reset(1'b0, 8'hF3, '0, 8'hFF);
    node_bit = 8'hF3;
    edges(6);
    chk("R4 masked counted as arrived", done_irq, 8'hF3);
    edges(1);
    chk("R4 masked gets no flag", done_flag, 8'hF3);
  endtask

  task automatic t_eureka;
    do_reset(1'b1, 8'hFF, '0, 8'h55);
    node_bit = 8'h40;
    edges(5);
    chk("R3 eureka before latency", done_irq, 8'h00);
    edges(1);
    chk("R6 irq only where enabled", done_irq, 8'h55);
    edges(1);
    chk("R3 eureka flags all", done_flag, 8'hFF);
    edges(10);
    chk("R9 eureka single completion", done_irq, 8'h00);
  endtask

  task automatic t_eureka_mask;
    do_reset(1'b1, 8'hDF, '0, 8'hFF);
    node_bit = 8'h20;
    edges(10);
    chk("R4 masked node silent irq", done_irq, 8'h00);
    chk("R4 masked node silent flag", done_flag, 8'h00);
    node_bit = 8'h24;
    edges(6);
    chk("R3 participant completes", done_irq, 8'hDF);
  endtask

  task automatic t_bypass_mid;
    logic [N-1:2] byp;
    byp = '0;
    byp[2] = 1'b1;
    do_reset(1'b0, 8'hFF, byp, 8'hFF);
    node_bit = 8'h0F;
    edges(3);
    chk("R5 subtree before 2h", done_irq, 8'h00);
    edges(1);
    chk("R5 subtree resolves alone", done_irq, 8'h0F);
    edges(1);
    chk("R5 subtree flags", done_flag, 8'h0F);
    node_bit = 8'hFF;
    edges(5);
    chk("R5 root before latency", done_irq, 8'h00);
    edges(1);
    chk("R5 root skips cut subtree", done_irq, 8'hF0);
    edges(1);
    chk("R5 all flags after both", done_flag, 8'hFF);
  endtask

  task automatic t_bypass_low;
    logic [N-1:2] byp;
    byp = '0;
    byp[7] = 1'b1;
    do_reset(1'b1, 8'hFF, byp, 8'hFF);
    node_bit = 8'h80;
    edges(1);
    chk("R5 bottom cut before 2h", done_irq, 8'h00);
    edges(1);
    chk("R5 bottom cut resolves", done_irq, 8'hC0);
    edges(10);
    chk("R5 rest of tree untouched irq", done_irq, 8'h00);
    chk("R5 rest of tree untouched flag", done_flag, 8'hC0);
  endtask

  initial begin
    t_barrier_round();
    t_barrier_mask();
    t_eureka();
    t_eureka_mask();
    t_bypass_mid();
    t_bypass_low();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule